// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. A 16-bit up-counter advances once per prescaled tick. Each tick comes from one of three tick-enable inputs, all synchronous to the bus clock, and then passes through a divider that divides by a power of four, from 1 up to 1024. When a prescaled tick arrives while the counter already equals the programmed compare value, the block raises a one-cycle reset request. A system reset controller downstream consumes that request.

To keep the system alive, software writes the counter register, normally with zero, before the timeout expires. To reconfigure the block, software first clears the enable bit. It then programs the compare and control registers, restarts the counter, and sets the enable bit again. Writes are single-cycle strobes. Reads are combinational from the address.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the compare, enable, counter and control registers all read 0, and `resetReq` is low.
- R2: The register map uses byte offsets. 0x0 holds the compare value (16 bits). 0x4 holds the enable in bit 0, and its other bits read 0. 0x8 is the live counter (16 bits). 0xC is the control register: bits 2:0 are the source select and bits 5:3 are the prescaler code, and bits 15:6 read 0. Any other address reads 0, and writes to it change nothing.
- R3: A write to 0x8 loads the written value into the counter on the write edge and clears the prescaler. Writing 0 restarts the timeout, so regular writes of 0 keep `resetReq` low.
- R4: While the enable bit is 0, the counter holds its value, the prescaler is cleared and no reset request is raised.
- R5: Control bit 0 selects `tickPclk`, bit 1 selects `tickRtc` and bit 2 selects `tickExt`. With no bit set, or with more than one bit set, no tick is counted and the counter stays where it is.
- R6: Prescaler code n, for n from 0 to 5, passes one prescaled tick per 4^n selected source ticks. Codes 6 and 7 divide by 1024.
- R7: Each prescaled tick adds one to the counter, unless the counter equals the compare value. Counting wraps from 0xFFFF to 0.
- R8: Start from counter value s with compare value c. The reset request then appears after exactly ((c - s) mod 65536 + 1) x divisor selected source ticks. It is high for the single cycle after the edge of the last of those ticks. The counter then holds at c, and no further request is raised until the counter is written or the block is disabled.
- R9: A counter write on the same edge as a prescaled tick takes precedence. The counter reads back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for `busAddr`, combinational |
| tickPclk | input | 1 | Tick enable, source 0 |
| tickRtc | input | 1 | Tick enable, source 1 |
| tickExt | input | 1 | Tick enable, source 2 |
| resetReq | output | 1 | One-cycle reset request pulse |

## Verification
A register write takes effect on the clock edge that samples it, and a read returns the new value half a cycle later. The counter moves on the same edge as the source tick that completes a prescaler period. The reset request is registered, so it is visible in the cycle after the edge of the final tick. The bench drives inputs and samples outputs on the falling edge. It counts the selected source ticks at each rising edge, starting with the first edge after the enable write. When it first sees the reset request, it compares that tick count with the arithmetic expectation from R8, and it checks on the next falling edge that the request has dropped again.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W    = 16;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 4;
  localparam int NSRC     = 3;
  localparam int CODE_W   = 3;
  localparam int MAX_CODE = 5;
  localparam int PRE_W    = 2 * MAX_CODE;

  // Configuration held by the register block.
  typedef struct packed {
    logic              enable;
    logic [CODE_W-1:0] preCode;
    logic [NSRC-1:0]   srcSel;
    logic [CNT_W-1:0]  cmpVal;
  } wdCfg_t;

  // Strobes from the register block to the datapath.
  typedef struct packed {
    logic             cntWr;
    logic [CNT_W-1:0] wrVal;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [CNT_W-1:0]  count,
  output wdCfg_t            cfg,
  output wdStrobe_t         strb,
  output logic [DATA_W-1:0] busRdData
);
  localparam logic [ADDR_W-1:0] ADDR_CMP = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] ADDR_EN  = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] ADDR_CNT = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] ADDR_CTL = ADDR_W'(4'hC);
  localparam int CTL_W = NSRC + CODE_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (busWrEn) begin
      case (busAddr)
        ADDR_CMP: cfg.cmpVal <= busWrData[CNT_W-1:0];
        ADDR_EN:  cfg.enable <= busWrData[0];
        ADDR_CTL: {cfg.preCode, cfg.srcSel} <= busWrData[CTL_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    strb.cntWr = busWrEn && (busAddr == ADDR_CNT);
    strb.wrVal = busWrData[CNT_W-1:0];
  end

  always_comb begin
    case (busAddr)
      ADDR_CMP: busRdData = DATA_W'(cfg.cmpVal);
      ADDR_EN:  busRdData = DATA_W'(cfg.enable);
      ADDR_CNT: busRdData = DATA_W'(count);
      ADDR_CTL: busRdData = DATA_W'({cfg.preCode, cfg.srcSel});
      default:  busRdData = '0;
    endcase
  end

  // R2: the control fields change only through a write to the control address
  a_r2_ctl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == ADDR_CTL) |=> $stable({cfg.preCode, cfg.srcSel}));

  // R2: the compare value changes only through a write to its own address
  a_r2_cmp_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == ADDR_CMP) |=> $stable(cfg.cmpVal));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wdCfg_t           cfg,
  input  wdStrobe_t        strb,
  input  logic [NSRC-1:0]  srcTicks,
  output logic [CNT_W-1:0] count,
  output logic             resetReq
);
  logic [NSRC-1:0]   selTick;
  logic              srcTick;
  logic [CODE_W-1:0] codeEff;
  logic [PRE_W-1:0]  preLimit;
  logic [PRE_W-1:0]  preCnt;
  logic              advance;
  logic              preHit;
  logic              atCmp;
  logic              fired;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign selTick[g] = cfg.srcSel[g] & srcTicks[g];
  end

  always_comb begin
    srcTick  = (|selTick) && $onehot(cfg.srcSel);
    codeEff  = (cfg.preCode > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : cfg.preCode;
    preLimit = (PRE_W'(1) << {codeEff, 1'b0}) - PRE_W'(1);
    advance  = cfg.enable && srcTick && !strb.cntWr;
    preHit   = advance && (preCnt == preLimit);
    atCmp    = (count == cfg.cmpVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!cfg.enable || strb.cntWr || preHit) begin
      preCnt <= '0;
    end else if (advance) begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      fired    <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= preHit && atCmp && !fired;
      if (strb.cntWr) begin
        count <= strb.wrVal;
        fired <= 1'b0;
      end else if (!cfg.enable) begin
        fired <= 1'b0;
      end else if (preHit) begin
        if (atCmp) fired <= 1'b1;
        else       count <= count + CNT_W'(1);
      end
    end
  end

  // R8: the request lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R8: when the request appears, the counter sits at the compare value of the previous cycle
  a_r8_hold_cmp: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> count == $past(cfg.cmpVal));

  // R4, R5: no counting while disabled or with an invalid source select
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((!cfg.enable || !$onehot(cfg.srcSel)) && !strb.cntWr) |=> $stable(count));

  // R4: no request while disabled
  a_r4_no_req_off: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> !resetReq);

  // R7: without a write, the counter moves by at most one
  a_r7_step: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntWr |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

  // R3, R9: a write loads the counter regardless of ticks
  a_r3_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntWr |=> count == $past(strb.wrVal));

  // R6: the prescaler stays inside its period
  a_r6_pre_bound: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preLimit);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              tickPclk,
  input  logic              tickRtc,
  input  logic              tickExt,
  output logic              resetReq
);
  wdCfg_t           cfg;
  wdStrobe_t        strb;
  logic [CNT_W-1:0] count;

  wdog_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .count     (count),
    .cfg       (cfg),
    .strb      (strb),
    .busRdData (busRdData)
  );

  wdog_core u_core (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .strb     (strb),
    .srcTicks ({tickExt, tickRtc, tickPclk}),
    .count    (count),
    .resetReq (resetReq)
  );
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CMP = 4'h0, A_EN = 4'h4, A_CNT = 4'h8, A_CTL = 4'hC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        tickPclk = 1'b1;
  logic        tickRtc = 1'b0;
  logic        tickExt = 1'b0;
  logic        resetReq;

  int checks = 0;
  int fails = 0;
  int phase = 0;
  int tickSeen = 0;
  int pulseCount = 0;
  bit arm = 1'b0;
  bit done = 1'b0;
  logic [2:0] selSrc = 3'd1;

  wdog_timer u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .tickPclk(tickPclk),
    .tickRtc(tickRtc), .tickExt(tickExt), .resetReq(resetReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Source tick patterns: pclk every cycle, rtc every 2nd, ext every 3rd.
  always @(negedge clk) begin
    phase   <= phase + 1;
    tickRtc <= (phase % 2 == 0);
    tickExt <= (phase % 3 == 0);
  end

  always @(posedge clk) begin
    if (!arm) tickSeen <= 0;
    else if ((selSrc == 3'd1 && tickPclk) || (selSrc == 3'd2 && tickRtc) ||
             (selSrc == 3'd4 && tickExt))
      tickSeen <= tickSeen + 1;
  end

  always @(negedge clk) if (resetReq) pulseCount <= pulseCount + 1;

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  function automatic int divOf(input int code);
    return 1 << (2 * ((code > 5) ? 5 : code));
  endfunction

  // Program, enable, and measure source ticks until the request (R8).
  task automatic runTimeout(input logic [2:0] src, input int code, input logic [15:0] cmp,
                            input logic [15:0] start, input string tag);
    int exp;
    int limit;
    bit seen;
    logic [15:0] v;
    exp = (int'(16'(cmp - start)) + 1) * divOf(code);
    limit = exp * 3 + 50;
    seen = 1'b0;
    wr(A_EN, 16'h0);
    arm = 1'b0;
    selSrc = src;
    wr(A_CTL, {10'd0, code[2:0], src});
    wr(A_CMP, cmp);
    wr(A_CNT, start);
    wr(A_EN, 16'h1);
    arm = 1'b1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (resetReq) begin seen = 1'b1; break; end
    end
    check(seen, {tag, " R8 request seen"}, int'(seen), 1);
    if (seen) begin
      check(tickSeen == exp, {tag, " R6 R8 ticks to request"}, tickSeen, exp);
      @(negedge clk);
      check(!resetReq, {tag, " R8 one-cycle pulse"}, int'(resetReq), 0);
      repeat (20) @(negedge clk);
      rd(A_CNT, v);
      check(v == cmp, {tag, " R8 held at compare"}, int'(v), int'(cmp));
      check(!resetReq, {tag, " R8 no repeat"}, int'(resetReq), 0);
    end
    arm = 1'b0;
    wr(A_EN, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    summary();
  end

  initial begin
    logic [15:0] v, c1;
    int p0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CMP, v); check(v == 0, "R1 compare", int'(v), 0);
    rd(A_EN,  v); check(v == 0, "R1 enable", int'(v), 0);
    rd(A_CNT, v); check(v == 0, "R1 counter", int'(v), 0);
    rd(A_CTL, v); check(v == 0, "R1 control", int'(v), 0);
    check(!resetReq, "R1 request", int'(resetReq), 0);

    // R2 register map and readback
    wr(A_CMP, 16'hA5C3); rd(A_CMP, v); check(v == 16'hA5C3, "R2 compare rw", int'(v), 'hA5C3);
    wr(A_CTL, 16'hFFFF); rd(A_CTL, v); check(v == 16'h003F, "R2 control rw", int'(v), 'h3F);
    wr(A_EN, 16'hFFFE);  rd(A_EN, v);  check(v == 16'h0000, "R2 enable bit0", int'(v), 0);
    wr(A_CTL, 16'h0000);
    wr(A_CNT, 16'h1234); rd(A_CNT, v); check(v == 16'h1234, "R3 counter load", int'(v), 'h1234);
    wr(4'h2, 16'hFFFF); wr(4'h6, 16'hFFFF); wr(4'hE, 16'hFFFF);
    rd(4'h2, v); check(v == 0, "R2 unmapped read", int'(v), 0);
    rd(A_CMP, v); check(v == 16'hA5C3, "R2 unmapped write ignored", int'(v), 'hA5C3);
    rd(A_CNT, v); check(v == 16'h1234, "R2 unmapped write ignored cnt", int'(v), 'h1234);
    rd(A_CTL, v); check(v == 16'h0000, "R2 unmapped write ignored ctl", int'(v), 0);

    // R6 prescaler sweep over all codes
    for (int code = 0; code < 8; code++)
      runTimeout(3'd1, code, 16'd3, 16'd0, $sformatf("R6 code%0d", code));

    // R5 each valid source
    runTimeout(3'd1, 1, 16'd2, 16'd0, "R5 pclk");
    runTimeout(3'd2, 1, 16'd2, 16'd0, "R5 rtc");
    runTimeout(3'd4, 1, 16'd2, 16'd0, "R5 ext");

    // R5 invalid selects count nothing
    for (int s = 0; s < 8; s++) begin
      if (s == 1 || s == 2 || s == 4) continue;
      wr(A_EN, 16'h0);
      wr(A_CTL, 16'(s));
      wr(A_CMP, 16'd1);
      wr(A_CNT, 16'd0);
      p0 = pulseCount;
      wr(A_EN, 16'h1);
      repeat (40) @(negedge clk);
      rd(A_CNT, v);
      check(v == 0, $sformatf("R5 select %0d no count", s), int'(v), 0);
      check(pulseCount == p0, $sformatf("R5 select %0d no request", s), pulseCount - p0, 0);
    end
    wr(A_EN, 16'h0);

    // R7 wrap from 0xFFFE past 0xFFFF to compare 2
    runTimeout(3'd1, 0, 16'd2, 16'hFFFE, "R7 wrap");

    // R4 disable holds the count
    wr(A_CTL, {10'd0, 3'd2, 3'd1});
    wr(A_CMP, 16'd100);
    wr(A_CNT, 16'd0);
    wr(A_EN, 16'h1);
    repeat (50) @(negedge clk);
    wr(A_EN, 16'h0);
    rd(A_CNT, c1);
    check(c1 != 0, "R4 counted while enabled", int'(c1), 3);
    repeat (40) @(negedge clk);
    rd(A_CNT, v);
    check(v == c1, "R4 held while disabled", int'(v), int'(c1));

    // R3 keep-alive and R9 write precedence
    wr(A_CTL, {10'd0, 3'd0, 3'd1});
    wr(A_CMP, 16'd20);
    wr(A_CNT, 16'd0);
    p0 = pulseCount;
    wr(A_EN, 16'h1);
    for (int k = 0; k < 10; k++) begin
      repeat (8) @(negedge clk);
      wr(A_CNT, 16'd0);
    end
    check(pulseCount == p0, "R3 keep-alive no request", pulseCount - p0, 0);
    wr(A_CNT, 16'd7);
    rd(A_CNT, v);
    check(v == 16'd7, "R9 write wins over tick", int'(v), 7);
    @(negedge clk);
    rd(A_CNT, v);
    check(v == 16'd8, "R7 next tick increments", int'(v), 8);
    wr(A_EN, 16'h0);

    summary();
  end
endmodule